// File: doc/BRIEF.md
# Crypto Command Intake Checker

This block sits at the front of a symmetric crypto engine. A command arrives as two 64-bit message words. The first word points at a control descriptor and the second at a packet descriptor. The decoded 64-bit instruction word of the control descriptor arrives alongside them. Each of the three words has its own valid/ready handshake and is held in its own slot until all three are present. The block then checks the instruction word and the framing for illegal settings. It builds a two-word completion message and holds it on the output until it is accepted.

Each illegal condition sets its own bit in a 9-bit error code, and the bits are ORed together. A code of zero means success. The control-side code goes into the first completion word and the data-side code into the second. A read-error sideband pulse seen at any time while the command is being collected is reported in both words.

Top module: `sec_cmd_intake`

## Requirements
- R1: Each input ready is high while its slot is empty. A word is taken on a cycle where valid and ready are both high. Ready then stays low and the held word stays unchanged until the completion message is launched.
- R2: The completion message becomes valid on the clock edge after the last of the three words is captured, whatever order the words arrive in. While rsp_ready_i is low, rsp_valid_o and both words stay stable. If a new command is already complete when the response is accepted, the next message is launched on that same edge.
- R3: Control error bit 0 (value 0x001) is set when the cipher field (instruction bits 34:32) is 6 or 7.
- R4: Control error bit 1 (0x002) is set in either of two cases. The first is when the mode field (bits 31:29) is 2, 3 or 4 and the cipher is not an AES code (3, 4 or 5). The second is when the mode is 5, 6 or 7.
- R5: Control error bit 2 (0x004) is set when checksum enable (bit 16) is 1 and the checksum-source field (bits 18:17) is 2 or 3.
- R6: Control error bit 3 (0x008) is set only when all of the following hold: the cipher is AES, the mode is 2 (CFB), the new-key flag (bit 28) is 1, mask bit 7 is 1, and any mask bit 6:0 is 1. The mask is instruction bits 7:0.
- R7: Control error bit 4 (0x010) is set when any instruction bit in 63:37 or 15:14 is 1. Bits 36:35 do not cause it.
- R8: Control error bit 8 (0x100) is set when the first word's tag (bits 63:61) differs from TAG_SOP (default 3'b001), or when the second word's tag differs from TAG_EOP (default 3'b010).
- R9: A pulse on rd_err_i at any time after the previous launch, up to and including the launch cycle, sets bit 7 (0x080) in both completion words. It is cleared for the next command.
- R10: When the load flag (second word bit 45) is 0, the data error code has bit 8 (0x100) set.
- R11: Each completion word is laid out as follows. RSP_TAG (default 3'b011) is in 63:61. The first word's destination id (its bits 60:54) is in 60:54. Bits 53:52 are zero. The source word's tag is in 51:49. The error code is in 48:40. The source word's address, with bits 4:0 forced to zero, is in 39:0.
- R12: After reset, rsp_valid_o is low and all three input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd0_valid_i | input | 1 | First command word valid |
| cmd0_ready_o | output | 1 | First command word slot empty |
| cmd0_data_i | input | 64 | First command word (control descriptor pointer) |
| cmd1_valid_i | input | 1 | Second command word valid |
| cmd1_ready_o | output | 1 | Second command word slot empty |
| cmd1_data_i | input | 64 | Second command word (packet descriptor pointer) |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_ready_o | output | 1 | Instruction word slot empty |
| instr_data_i | input | 64 | Decoded instruction word |
| rd_err_i | input | 1 | Descriptor read error sideband |
| rsp_valid_o | output | 1 | Completion message valid |
| rsp_ready_i | input | 1 | Completion message accepted |
| rsp_ctl_o | output | 64 | Completion word for the control descriptor |
| rsp_dat_o | output | 64 | Completion word for the packet descriptor |

## Verification
The hardest situation to reach from the ports is a back-to-back hand-off. A second command must fill all three slots while the first completion is still stalled, and the stall must then be released so that acceptance and the next launch share one edge. The bench holds rsp_ready_i low and pushes the second command in behind the stalled response. It confirms that the inputs are back-pressured and the old message is frozen. It then releases the response for a single cycle and expects the new message at once. The sticky read error is reached by pulsing the sideband while the block is idle, before any word arrives.

// File: rtl/sec_intake_pkg.sv
package sec_intake_pkg;
  localparam int WORD_W   = 64;
  localparam int TAG_W    = 3;
  localparam int ID_W     = 7;
  localparam int ERR_W    = 9;
  localparam int ADDR_W   = 40;
  localparam int TAG_LSB  = 61;
  localparam int ID_LSB   = 54;
  localparam int LOAD_BIT = 45;

  // instruction word fields
  localparam int CPHR_LSB   = 32;
  localparam int MODE_LSB   = 29;
  localparam int NEWKEY_BIT = 28;
  localparam int CSRC_LSB   = 17;
  localparam int CKS_BIT    = 16;
  localparam int MASK_LSB   = 0;

  // error bit indices
  localparam int E_CIPHER = 0;
  localparam int E_MODE   = 1;
  localparam int E_CSRC   = 2;
  localparam int E_MASK   = 3;
  localparam int E_RSVD   = 4;
  localparam int E_RDERR  = 7;
  localparam int E_FRAME  = 8;
  localparam int E_NOLOAD = 8;

  localparam logic [2:0] MODE_CFB = 3'd2;

  typedef struct packed {
    logic [2:0] cipher;
    logic [2:0] mode;
    logic       new_key;
    logic       cks_en;
    logic [1:0] cks_src;
    logic [7:0] mask;
    logic       rsvd_hit;
  } instr_dec_t;

  function automatic instr_dec_t decode_instr(input logic [WORD_W-1:0] w);
    instr_dec_t d;
    d.cipher   = w[CPHR_LSB +: 3];
    d.mode     = w[MODE_LSB +: 3];
    d.new_key  = w[NEWKEY_BIT];
    d.cks_en   = w[CKS_BIT];
    d.cks_src  = w[CSRC_LSB +: 2];
    d.mask     = w[MASK_LSB +: 8];
    d.rsvd_hit = (|w[63:37]) | (|w[15:14]);
    return d;
  endfunction
endpackage

// File: rtl/sec_word_slot.sv
module sec_word_slot
  import sec_intake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ready_o,
  input  logic              clr_i,
  output logic              full_o,
  output logic [WORD_W-1:0] data_o
);
  logic              full_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;

  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !clr_i |=> full_q && $stable(data_q)); // R1
  AST_SLOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !full_q); // R1
endmodule

// File: rtl/sec_instr_check.sv
module sec_instr_check
  import sec_intake_pkg::*;
#(
  parameter logic [TAG_W-1:0] TAG_SOP = 3'b001,
  parameter logic [TAG_W-1:0] TAG_EOP = 3'b010
) (
  input  logic [WORD_W-1:0] instr_i,
  input  logic [TAG_W-1:0]  tag0_i,
  input  logic [TAG_W-1:0]  tag1_i,
  input  logic              load_i,
  input  logic              rd_err_i,
  output logic [ERR_W-1:0]  ctl_err_o,
  output logic [ERR_W-1:0]  dat_err_o
);
  instr_dec_t d;
  logic       is_aes;

  always_comb begin
    d         = decode_instr(instr_i);
    is_aes    = (d.cipher >= 3'd3) && (d.cipher <= 3'd5);
    ctl_err_o = '0;
    ctl_err_o[E_CIPHER] = d.cipher[2] & d.cipher[1];
    ctl_err_o[E_MODE]   = ((d.mode >= 3'd2) && (d.mode <= 3'd4) && !is_aes)
                          || (d.mode >= 3'd5);
    ctl_err_o[E_CSRC]   = d.cks_en & d.cks_src[1];
    ctl_err_o[E_MASK]   = is_aes && (d.mode == MODE_CFB) && d.new_key
                          && d.mask[7] && (|d.mask[6:0]);
    ctl_err_o[E_RSVD]   = d.rsvd_hit;
    ctl_err_o[E_RDERR]  = rd_err_i;
    ctl_err_o[E_FRAME]  = (tag0_i != TAG_SOP) || (tag1_i != TAG_EOP);
    dat_err_o = '0;
    dat_err_o[E_RDERR]  = rd_err_i;
    dat_err_o[E_NOLOAD] = !load_i;
  end
endmodule

// File: rtl/sec_rsp_pack.sv
module sec_rsp_pack
  import sec_intake_pkg::*;
#(
  parameter logic [TAG_W-1:0] RSP_TAG  = 3'b011,
  parameter int               LINE_LSB = 5
) (
  input  logic [WORD_W-1:0] desc_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic [WORD_W-1:0] rsp_o
);
  assign rsp_o = {RSP_TAG, id_i, 2'b00, desc_i[TAG_LSB +: TAG_W], err_i,
                  desc_i[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
endmodule

// File: rtl/sec_cmd_intake.sv
module sec_cmd_intake
  import sec_intake_pkg::*;
#(
  parameter logic [2:0] TAG_SOP  = 3'b001,
  parameter logic [2:0] TAG_EOP  = 3'b010,
  parameter logic [2:0] RSP_TAG  = 3'b011,
  parameter int         LINE_LSB = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd0_valid_i,
  output logic        cmd0_ready_o,
  input  logic [63:0] cmd0_data_i,
  input  logic        cmd1_valid_i,
  output logic        cmd1_ready_o,
  input  logic [63:0] cmd1_data_i,
  input  logic        instr_valid_i,
  output logic        instr_ready_o,
  input  logic [63:0] instr_data_i,
  input  logic        rd_err_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [63:0] rsp_ctl_o,
  output logic [63:0] rsp_dat_o
);
  localparam int NSLOT = 3;
  localparam int NRSP  = 2;

  logic [NSLOT-1:0]  s_vld, s_rdy, s_full;
  logic [WORD_W-1:0] s_din [NSLOT];
  logic [WORD_W-1:0] s_q   [NSLOT];
  logic [ERR_W-1:0]  err   [NRSP];
  logic [WORD_W-1:0] pk    [NRSP];
  logic              launch, rd_err_q, rd_err_any, rsp_valid_q;
  logic [WORD_W-1:0] rsp_ctl_q, rsp_dat_q;

  assign s_vld    = {instr_valid_i, cmd1_valid_i, cmd0_valid_i};
  assign s_din[0] = cmd0_data_i;
  assign s_din[1] = cmd1_data_i;
  assign s_din[2] = instr_data_i;
  assign {instr_ready_o, cmd1_ready_o, cmd0_ready_o} = s_rdy;

  assign launch = (&s_full) && (!rsp_valid_q || rsp_ready_i);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    sec_word_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (s_vld[g]),
      .data_i  (s_din[g]),
      .ready_o (s_rdy[g]),
      .clr_i   (launch),
      .full_o  (s_full[g]),
      .data_o  (s_q[g])
    );
  end

  // sticky read error, collected between launches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_err_q <= 1'b0;
    else if (launch) rd_err_q <= 1'b0;
    else if (rd_err_i) rd_err_q <= 1'b1;
  end
  assign rd_err_any = rd_err_q | rd_err_i;

  sec_instr_check #(.TAG_SOP(TAG_SOP), .TAG_EOP(TAG_EOP)) u_check (
    .instr_i   (s_q[2]),
    .tag0_i    (s_q[0][TAG_LSB +: TAG_W]),
    .tag1_i    (s_q[1][TAG_LSB +: TAG_W]),
    .load_i    (s_q[1][LOAD_BIT]),
    .rd_err_i  (rd_err_any),
    .ctl_err_o (err[0]),
    .dat_err_o (err[1])
  );

  for (genvar r = 0; r < NRSP; r++) begin : g_pack
    sec_rsp_pack #(.RSP_TAG(RSP_TAG), .LINE_LSB(LINE_LSB)) u_pack (
      .desc_i (s_q[r]),
      .id_i   (s_q[0][ID_LSB +: ID_W]),
      .err_i  (err[r]),
      .rsp_o  (pk[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_ctl_q   <= '0;
      rsp_dat_q   <= '0;
    end else if (launch) begin
      rsp_valid_q <= 1'b1;
      rsp_ctl_q   <= pk[0];
      rsp_dat_q   <= pk[1];
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_ctl_o   = rsp_ctl_q;
  assign rsp_dat_o   = rsp_dat_q;

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_ctl_o) && $stable(rsp_dat_o)); // R2
  AST_RSP_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o ##1 rsp_valid_o |-> $past(&s_full)); // R2
  AST_LINE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_ctl_o[LINE_LSB-1:0] == '0) && (rsp_dat_o[LINE_LSB-1:0] == '0)); // R11
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_ctl_o[53:52] == 2'b00) && (rsp_dat_o[53:52] == 2'b00)); // R11
  AST_RDERR_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_ctl_o[47] == rsp_dat_o[47]); // R9
endmodule

// File: tb/sec_cmd_intake_tb.sv
module sec_cmd_intake_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c0_v = 0, c1_v = 0, in_v = 0, rd_err = 0, rsp_rdy = 0;
  logic [63:0] c0_d = '0, c1_d = '0, in_d = '0;
  logic        c0_r, c1_r, in_r, rsp_v;
  logic [63:0] rsp_c, rsp_d;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  sec_cmd_intake u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd0_valid_i(c0_v), .cmd0_ready_o(c0_r), .cmd0_data_i(c0_d),
    .cmd1_valid_i(c1_v), .cmd1_ready_o(c1_r), .cmd1_data_i(c1_d),
    .instr_valid_i(in_v), .instr_ready_o(in_r), .instr_data_i(in_d),
    .rd_err_i(rd_err),
    .rsp_valid_o(rsp_v), .rsp_ready_i(rsp_rdy),
    .rsp_ctl_o(rsp_c), .rsp_dat_o(rsp_d)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_w0(input logic [2:0] tag, input logic [6:0] id, input logic [39:0] addr);
    logic [63:0] w = '0;
    w[63:61] = tag; w[60:54] = id; w[48:45] = 4'd3; w[39:0] = addr;
    return w;
  endfunction

  function automatic logic [63:0] mk_w1(input logic [2:0] tag, input logic ld, input logic [39:0] addr);
    logic [63:0] w = '0;
    w[63:61] = tag; w[45] = ld; w[39:0] = addr;
    return w;
  endfunction

  function automatic logic [63:0] mk_ins(input logic [2:0] cph, input logic [2:0] md, input logic nk,
                                         input logic cks, input logic [1:0] src, input logic [7:0] msk);
    logic [63:0] w = '0;
    w[34:32] = cph; w[31:29] = md; w[28] = nk; w[16] = cks; w[18:17] = src; w[7:0] = msk;
    return w;
  endfunction

  function automatic logic [63:0] exp_rsp(input logic [63:0] desc, input logic [6:0] id, input logic [8:0] e);
    return {3'b011, id, 2'b00, desc[63:61], e, desc[39:5], 5'b00000};
  endfunction

  task automatic run(input string req, input logic [63:0] w0, input logic [63:0] w1,
                     input logic [63:0] ins, input logic [8:0] ec, input logic [8:0] ed, input bit stagger);
    @(negedge clk);
    if (stagger) begin
      in_v = 1; in_d = ins;
      @(negedge clk); in_v = 0;
      chk(in_r == 0, "R1 instr slot held", {63'b0, in_r}, 64'd0);
      c1_v = 1; c1_d = w1;
      @(negedge clk); c1_v = 0;
      chk(rsp_v == 0, "R2 no response before all words", {63'b0, rsp_v}, 64'd0);
      c0_v = 1; c0_d = w0;
      @(negedge clk); c0_v = 0;
    end else begin
      c0_v = 1; c0_d = w0; c1_v = 1; c1_d = w1; in_v = 1; in_d = ins;
      @(negedge clk); c0_v = 0; c1_v = 0; in_v = 0;
      chk({c0_r, c1_r, in_r} == 3'b000, "R1 readies low while held", {61'b0, c0_r, c1_r, in_r}, 64'd0);
    end
    @(negedge clk);
    chk(rsp_v == 1, "R2 response valid", {63'b0, rsp_v}, 64'd1);
    chk(rsp_c == exp_rsp(w0, w0[60:54], ec), {req, " ctl word"}, rsp_c, exp_rsp(w0, w0[60:54], ec));
    chk(rsp_d == exp_rsp(w1, w0[60:54], ed), {req, " dat word"}, rsp_d, exp_rsp(w1, w0[60:54], ed));
    rsp_rdy = 1;
    @(negedge clk); rsp_rdy = 0;
    chk(rsp_v == 0 && {c0_r, c1_r, in_r} == 3'b111, "R1 R2 idle after accept",
        {60'b0, rsp_v, c0_r, c1_r, in_r}, 64'd7);
  endtask

  localparam logic [2:0] SOP = 3'b001, EOP = 3'b010;
  logic [63:0] W0, W1;

  task automatic t_legal();
    run("R11 legal staggered", W0, W1, mk_ins(3'd3, 3'd1, 0, 0, 0, 0), 9'h000, 9'h000, 1);
    run("R11 legal aes ctr", W0, W1, mk_ins(3'd5, 3'd4, 1, 1, 2'd1, 8'hff), 9'h000, 9'h000, 0);
  endtask
  task automatic t_cipher();
    run("R3 cipher 6", W0, W1, mk_ins(3'd6, 3'd0, 0, 0, 0, 0), 9'h001, 9'h000, 0);
    run("R3 cipher 7", W0, W1, mk_ins(3'd7, 3'd1, 0, 0, 0, 0), 9'h001, 9'h000, 0);
  endtask
  task automatic t_mode();
    run("R4 ofb with des", W0, W1, mk_ins(3'd1, 3'd3, 0, 0, 0, 0), 9'h002, 9'h000, 0);
    run("R4 mode 5 with aes", W0, W1, mk_ins(3'd4, 3'd5, 0, 0, 0, 0), 9'h002, 9'h000, 0);
  endtask
  task automatic t_cksum();
    run("R5 cksum src 2", W0, W1, mk_ins(3'd1, 3'd0, 0, 1, 2'd2, 0), 9'h004, 9'h000, 0);
    run("R5 src 3 cksum off", W0, W1, mk_ins(3'd1, 3'd0, 0, 0, 2'd3, 0), 9'h000, 9'h000, 0);
  endtask
  task automatic t_mask();
    run("R6 cfb mask bad", W0, W1, mk_ins(3'd3, 3'd2, 1, 0, 0, 8'h81), 9'h008, 9'h000, 0);
    run("R6 mask only bit7", W0, W1, mk_ins(3'd3, 3'd2, 1, 0, 0, 8'h80), 9'h000, 9'h000, 0);
    run("R6 old keys", W0, W1, mk_ins(3'd3, 3'd2, 0, 0, 0, 8'h81), 9'h000, 9'h000, 0);
  endtask
  task automatic t_rsvd();
    logic [63:0] i = mk_ins(3'd1, 3'd0, 0, 0, 0, 0);
    i[40] = 1'b1;
    run("R7 bit 40", W0, W1, i, 9'h010, 9'h000, 0);
    i[40] = 1'b0; i[15] = 1'b1;
    run("R7 bit 15", W0, W1, i, 9'h010, 9'h000, 0);
    i[15] = 1'b0; i[36] = 1'b1;
    run("R7 bit 36 allowed", W0, W1, i, 9'h000, 9'h000, 0);
  endtask
  task automatic t_frame();
    run("R8 first tag eop", mk_w0(EOP, 7'h15, 40'h12_3456_789f), W1,
        mk_ins(3'd1, 3'd0, 0, 0, 0, 0), 9'h100, 9'h000, 0);
    run("R8 second tag sop", W0, mk_w1(SOP, 1, 40'hab_cdef_0123),
        mk_ins(3'd1, 3'd0, 0, 0, 0, 0), 9'h100, 9'h000, 0);
  endtask
  task automatic t_rderr();
    @(negedge clk); rd_err = 1;
    @(negedge clk); rd_err = 0;
    repeat (2) @(negedge clk);
    run("R9 read error sticky", W0, W1, mk_ins(3'd1, 3'd0, 0, 0, 0, 0), 9'h080, 9'h080, 0);
    run("R9 cleared next", W0, W1, mk_ins(3'd1, 3'd0, 0, 0, 0, 0), 9'h000, 9'h000, 0);
  endtask
  task automatic t_noload();
    run("R10 no load", W0, mk_w1(EOP, 0, 40'h00_0000_1040),
        mk_ins(3'd2, 3'd1, 0, 0, 0, 0), 9'h000, 9'h100, 0);
  endtask
  task automatic t_combo();
    logic [63:0] i = mk_ins(3'd7, 3'd6, 0, 0, 0, 0);
    i[14] = 1'b1;
    run("R3 R4 R7 combined", W0, W1, i, 9'h013, 9'h000, 0);
  endtask
  task automatic t_backpressure();
    logic [63:0] ia = mk_ins(3'd6, 3'd0, 0, 0, 0, 0);
    logic [63:0] ib = mk_ins(3'd1, 3'd0, 0, 0, 0, 0);
    logic [63:0] w0b = mk_w0(SOP, 7'h2a, 40'h55_0000_0040);
    @(negedge clk);
    c0_v = 1; c0_d = W0; c1_v = 1; c1_d = W1; in_v = 1; in_d = ia;
    @(negedge clk); c0_v = 0; c1_v = 0; in_v = 0;
    @(negedge clk);
    chk(rsp_v == 1, "R2 first response", {63'b0, rsp_v}, 64'd1);
    c0_v = 1; c0_d = w0b; c1_v = 1; c1_d = W1; in_v = 1; in_d = ib;
    @(negedge clk); c0_v = 0; c1_v = 0; in_v = 0;
    @(negedge clk);
    chk({c0_r, c1_r, in_r} == 3'b000, "R1 back-pressured", {61'b0, c0_r, c1_r, in_r}, 64'd0);
    chk(rsp_v && rsp_c == exp_rsp(W0, W0[60:54], 9'h001), "R2 stalled response stable",
        rsp_c, exp_rsp(W0, W0[60:54], 9'h001));
    rsp_rdy = 1;
    @(negedge clk); rsp_rdy = 0;
    chk(rsp_v && rsp_c == exp_rsp(w0b, 7'h2a, 9'h000), "R2 same-edge relaunch ctl",
        rsp_c, exp_rsp(w0b, 7'h2a, 9'h000));
    chk(rsp_d == exp_rsp(W1, 7'h2a, 9'h000), "R11 relaunch dat uses new id",
        rsp_d, exp_rsp(W1, 7'h2a, 9'h000));
    rsp_rdy = 1;
    @(negedge clk); rsp_rdy = 0;
    chk(rsp_v == 0, "R2 drained", {63'b0, rsp_v}, 64'd0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    W0 = mk_w0(SOP, 7'h15, 40'h12_3456_789f);
    W1 = mk_w1(EOP, 1, 40'hab_cdef_0133);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_v == 0 && {c0_r, c1_r, in_r} == 3'b111, "R12 reset state",
        {60'b0, rsp_v, c0_r, c1_r, in_r}, 64'd7);
    t_legal();
    t_cipher();
    t_mode();
    t_cksum();
    t_mask();
    t_rsvd();
    t_frame();
    t_rderr();
    t_noload();
    t_combo();
    t_backpressure();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule